// File: doc/BRIEF.md
# Max-Log-MAP Soft-Output and Extrinsic Stage

This block is the soft-output end of a sliding-window Max-Log-MAP turbo decoder built around an 8-state recursive systematic constituent code. For every trellis step it receives eight stored forward state metrics, eight backward state metrics from the running backward recursion, and four branch metrics. The branch metrics are indexed by the 2-bit codeword made of the input bit and the parity bit. Sixteen parallel cells form forward + branch + backward sums, one per trellis transition. Two maximum searches then take the best transition whose input bit is 1 and the best whose input bit is 0. Their difference is the a-posteriori log-likelihood ratio.

The extrinsic value is the LLR minus the systematic channel term and the a-priori term. It is clamped into a signed 6-bit word with two fractional bits, so its range is −8.00 to +7.75. The backward recursion produces a window's symbols last-first. A two-bank last-in-first-out store therefore collects each window and replays it in natural time order once the window's final symbol has arrived. While one bank drains, the next window fills the other bank.

Top module: `llr_ext_unit`

## Requirements
- R1: Trellis state s is 3 bits {d2,d1,d0}. For input bit u the feedback bit is a = u^d1^d2, the parity bit is p = a^d0^d2, and the next state is {d1,d0,a}. Each of the 16 transitions (s,u) sums alpha[s] + gamma[{u,p}] + beta[next], where alpha_i, beta_i and gamma_i are packed with index 0 in the least significant slice.
- R2: llr_o equals the largest transition sum with u=1 minus the largest transition sum with u=0, in full precision with no loss.
- R3: ext_o is llr − sys_i − apri_i saturated to signed 6 bits. All soft values use two fractional bits, so code 31 means +7.75 and code −32 means −8.00.
- R4: An unsaturated extrinsic of exactly 31 or −32 passes unchanged. A value of 32 or more gives 31, and a value of −33 or less gives −32.
- R5: For each window, the results come out in reverse order of the backward-pass input, so the last symbol pushed is the first one out. They are emitted one per cycle, with out_valid_o high for each result.
- R6: When the output side is idle, the first result of a window appears on the third clock edge after the edge that samples the window's in_last_i symbol. Consecutive windows' drains are separated by exactly one cycle with out_valid_o low.
- R7: Window lengths from 1 to WIN_LEN are accepted. in_valid_i is low for at least one cycle after each in_last_i symbol. A window may fill while the previous one drains, provided the window two before it has fully drained.
- R8: During and after reset, out_valid_o stays low until a window has completed.
- R9: Cycles with in_valid_i low are ignored whatever the data inputs carry. A window may contain such gaps between its symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Symbol metrics valid this cycle |
| in_last_i | input | 1 | Marks the final symbol of a window |
| alpha_i | input | 8*METRIC_W | Forward state metrics, signed, state 0 in low slice |
| beta_i | input | 8*METRIC_W | Backward state metrics, signed, state 0 in low slice |
| gamma_i | input | 4*GAMMA_W | Branch metrics, signed, indexed by codeword {u,p} |
| sys_i | input | IN_W | Systematic channel term, signed, 2 fractional bits |
| apri_i | input | IN_W | A-priori term, signed, 2 fractional bits |
| out_valid_o | output | 1 | Result pair valid |
| llr_o | output | METRIC_W+3 | A-posteriori LLR, signed |
| ext_o | output | 6 | Saturated extrinsic value, signed, 2 fractional bits |

## Verification
The hardest situation to reach is an exact clamp boundary, because the extrinsic value is the difference of two eight-way maxima, a channel term and an a-priori term. The stimulus makes this controllable by setting every state metric to zero and loading the same value into both branch metrics with u=1. The LLR then equals that value, and the systematic and a-priori inputs shift the result onto 31, 32, −32 and −33. The second delicate point is the one-cycle gap when one bank hands over to the other. Runs of equal-length windows separated by a single idle input cycle, including windows of one symbol, keep both banks in use at once.

// File: rtl/llrx_pkg.sv
// Package for the soft-output stage.
// Holds the trellis geometry and the constituent code's connectivity.
// Assumes an 8-state code with feedback taps on d1,d2 and parity taps on d0,d2.
package llrx_pkg;

    localparam int NUM_ST = 8;
    localparam int NUM_BR = 2 * NUM_ST;
    localparam int NUM_CW = 4;
    localparam int EXT_W  = 6;

    // Next state reached from state s under input bit u.
    function automatic logic [2:0] nxt_state(input logic [2:0] s, input logic u);
        logic fb;
        fb = u ^ s[1] ^ s[2];
        return {s[1:0], fb};
    endfunction

    // Parity bit emitted on the transition from s under input bit u.
    function automatic logic par_bit(input logic [2:0] s, input logic u);
        logic fb;
        fb = u ^ s[1] ^ s[2];
        return fb ^ s[0] ^ s[2];
    endfunction

endpackage

// File: rtl/llrx_branch_sums.sv
// Sixteen transition-sum cells with one register stage.
// Each cell adds the forward metric of its start state, the branch metric of
// its codeword and the backward metric of its end state. The cell index is
// {u, s}, so cells 0..7 carry u=0 and cells 8..15 carry u=1.
// Assumes SUM_W is at least two bits wider than both input metric widths.
module llrx_branch_sums #(
    parameter int METRIC_W = 10,
    parameter int GAMMA_W  = 8,
    parameter int SUM_W    = 12
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    en_i,
    input  logic [llrx_pkg::NUM_ST*METRIC_W-1:0]    alpha_i,
    input  logic [llrx_pkg::NUM_ST*METRIC_W-1:0]    beta_i,
    input  logic [llrx_pkg::NUM_CW*GAMMA_W-1:0]     gamma_i,
    output logic signed [SUM_W-1:0]                 sums_q [llrx_pkg::NUM_BR]
);
    import llrx_pkg::*;

    logic signed [SUM_W-1:0] cell_sum [NUM_BR];

    for (genvar b = 0; b < NUM_BR; b++) begin : g_cell
        localparam logic [2:0] S_L  = 3'(b % NUM_ST);
        localparam logic       U_L  = (b >= NUM_ST);
        localparam int         SI   = b % NUM_ST;
        localparam int         NSI  = int'(nxt_state(S_L, U_L));
        localparam int         CWI  = int'({U_L, par_bit(S_L, U_L)});

        logic signed [METRIC_W-1:0] a_s;
        logic signed [METRIC_W-1:0] b_s;
        logic signed [GAMMA_W-1:0]  g_s;

        assign a_s = alpha_i[SI*METRIC_W +: METRIC_W];
        assign b_s = beta_i[NSI*METRIC_W +: METRIC_W];
        assign g_s = gamma_i[CWI*GAMMA_W +: GAMMA_W];
        assign cell_sum[b] = SUM_W'(a_s) + SUM_W'(g_s) + SUM_W'(b_s);
    end

    // Capture all sixteen sums when a symbol is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BR; i++) sums_q[i] <= '0;
        end else if (en_i) begin
            for (int i = 0; i < NUM_BR; i++) sums_q[i] <= cell_sum[i];
        end
    end

endmodule

// File: rtl/llrx_max_tree.sv
// Signed maximum over N candidates, built as a balanced pairwise tree.
// Purely combinational; assumes N is a power of two.
module llrx_max_tree #(
    parameter int N = 8,
    parameter int W = 12
) (
    input  logic signed [W-1:0] vals_i [N],
    output logic signed [W-1:0] max_o
);
    localparam int LVLS = $clog2(N);

    logic signed [W-1:0] node [LVLS+1][N];

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[0][i] = vals_i[i];
    end

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar j = 0; j < (N >> (l + 1)); j++) begin : g_pair
            assign node[l+1][j] = (node[l][2*j] >= node[l][2*j+1]) ?
                                  node[l][2*j] : node[l][2*j+1];
        end
        for (genvar j = (N >> (l + 1)); j < N; j++) begin : g_pad
            assign node[l+1][j] = '0;
        end
    end

    assign max_o = node[LVLS][0];

endmodule

// File: rtl/llrx_ext_sat.sv
// Clamps a wide signed extrinsic value into EXT_W signed bits.
// The positive limit is 2^(EXT_W-1)-1 and the negative limit is -2^(EXT_W-1).
// Combinational; assumes RAW_W > EXT_W.
module llrx_ext_sat #(
    parameter int RAW_W = 15,
    parameter int EXT_W = 6
) (
    input  logic signed [RAW_W-1:0] raw_i,
    output logic signed [EXT_W-1:0] ext_o
);
    localparam int HI_I = 2 ** (EXT_W - 1) - 1;
    localparam int LO_I = -(2 ** (EXT_W - 1));
    localparam logic signed [RAW_W-1:0] HI_R = RAW_W'(HI_I);
    localparam logic signed [RAW_W-1:0] LO_R = RAW_W'(LO_I);

    // Select the limit or the value itself.
    always_comb begin
        if (raw_i > HI_R)      ext_o = EXT_W'(HI_I);
        else if (raw_i < LO_R) ext_o = EXT_W'(LO_I);
        else                   ext_o = raw_i[EXT_W-1:0];
    end

endmodule

// File: rtl/llrx_window_lifo.sv
// Two-bank last-in-first-out reorder store.
// Symbols of a window fill one bank. The push flagged last closes the bank,
// and the closed bank is replayed newest-first, one entry per cycle.
// Banks alternate for both filling and draining.
// Assumes a window is at most DEPTH long and that a bank is closed again only
// after its previous contents have drained.
module llrx_window_lifo #(
    parameter int DATA_W = 19,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              last_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pop_vld_o,
    output logic [DATA_W-1:0] pop_data_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem_q [2][DEPTH];
    logic              wr_bank_q;
    logic              rd_bank_q;
    logic              drain_q;
    logic [IDX_W-1:0]  wr_idx_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic [CNT_W-1:0]  len_q  [2];
    logic              full_q [2];
    logic              pop_done;

    assign pop_done = drain_q && (rd_idx_q == '0);

    // Advance the fill position; switch banks after the window's last symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank_q <= 1'b0;
            wr_idx_q  <= '0;
        end else if (push_i) begin
            if (last_i) begin
                wr_idx_q  <= '0;
                wr_bank_q <= ~wr_bank_q;
            end else begin
                wr_idx_q  <= wr_idx_q + 1'b1;
            end
        end
    end

    // Store each pushed entry in the filling bank.
    always_ff @(posedge clk) begin
        if (push_i) mem_q[wr_bank_q][wr_idx_q] <= data_i;
    end

    for (genvar k = 0; k < 2; k++) begin : g_bank
        // Mark a bank closed with its length, and free it after its last pop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q[k] <= 1'b0;
                len_q[k]  <= '0;
            end else if (push_i && last_i && (wr_bank_q == 1'(k))) begin
                full_q[k] <= 1'b1;
                len_q[k]  <= CNT_W'(wr_idx_q) + 1'b1;
            end else if (pop_done && (rd_bank_q == 1'(k))) begin
                full_q[k] <= 1'b0;
            end
        end
    end

    // Start draining a closed bank from its newest entry, then step downward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_q   <= 1'b0;
            rd_bank_q <= 1'b0;
            rd_idx_q  <= '0;
        end else if (!drain_q) begin
            if (full_q[rd_bank_q]) begin
                drain_q  <= 1'b1;
                rd_idx_q <= IDX_W'(len_q[rd_bank_q] - 1'b1);
            end
        end else if (pop_done) begin
            drain_q   <= 1'b0;
            rd_bank_q <= ~rd_bank_q;
        end else begin
            rd_idx_q  <= rd_idx_q - 1'b1;
        end
    end

    // Register the popped entry and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_vld_o  <= 1'b0;
            pop_data_o <= '0;
        end else begin
            pop_vld_o <= drain_q;
            if (drain_q) pop_data_o <= mem_q[rd_bank_q][rd_idx_q];
        end
    end

endmodule

// File: rtl/llr_ext_unit.sv
// Max-Log-MAP soft-output and extrinsic stage (top).
// Pipeline: register 16 transition sums -> two 8-way maxima -> LLR and
// saturated extrinsic -> two-bank LIFO that restores natural symbol order.
// Assumes GAMMA_W <= METRIC_W and IN_W <= METRIC_W + 3. The upstream leaves
// in_valid_i low for one cycle after every window's last symbol.
module llr_ext_unit #(
    parameter int WIN_LEN  = 16,
    parameter int METRIC_W = 10,
    parameter int GAMMA_W  = 8,
    parameter int IN_W     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid_i,
    input  logic                                  in_last_i,
    input  logic [llrx_pkg::NUM_ST*METRIC_W-1:0]  alpha_i,
    input  logic [llrx_pkg::NUM_ST*METRIC_W-1:0]  beta_i,
    input  logic [llrx_pkg::NUM_CW*GAMMA_W-1:0]   gamma_i,
    input  logic [IN_W-1:0]                       sys_i,
    input  logic [IN_W-1:0]                       apri_i,
    output logic                                  out_valid_o,
    output logic [METRIC_W+2:0]                   llr_o,
    output logic [llrx_pkg::EXT_W-1:0]            ext_o
);
    import llrx_pkg::*;

    localparam int SUM_W  = METRIC_W + 2;
    localparam int LLR_W  = SUM_W + 1;
    localparam int RAW_W  = LLR_W + 2;
    localparam int DATA_W = LLR_W + EXT_W;

    logic signed [SUM_W-1:0]  sums_q  [NUM_BR];
    logic signed [SUM_W-1:0]  sums_u0 [NUM_ST];
    logic signed [SUM_W-1:0]  sums_u1 [NUM_ST];
    logic signed [SUM_W-1:0]  max_u0;
    logic signed [SUM_W-1:0]  max_u1;
    logic signed [IN_W-1:0]   sys_q;
    logic signed [IN_W-1:0]   apri_q;
    logic                     vld_q;
    logic                     last_q;
    logic signed [LLR_W-1:0]  llr_c;
    logic signed [RAW_W-1:0]  ext_raw;
    logic signed [EXT_W-1:0]  ext_sat;
    logic [DATA_W-1:0]        pop_data;

    llrx_branch_sums #(
        .METRIC_W (METRIC_W),
        .GAMMA_W  (GAMMA_W),
        .SUM_W    (SUM_W)
    ) u_sums (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (in_valid_i),
        .alpha_i (alpha_i),
        .beta_i  (beta_i),
        .gamma_i (gamma_i),
        .sums_q  (sums_q)
    );

    // Carry the scalar side terms and window framing alongside the sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            last_q <= 1'b0;
            sys_q  <= '0;
            apri_q <= '0;
        end else begin
            vld_q  <= in_valid_i;
            last_q <= in_valid_i & in_last_i;
            if (in_valid_i) begin
                sys_q  <= sys_i;
                apri_q <= apri_i;
            end
        end
    end

    for (genvar i = 0; i < NUM_ST; i++) begin : g_split
        assign sums_u0[i] = sums_q[i];
        assign sums_u1[i] = sums_q[i + NUM_ST];
    end

    llrx_max_tree #(.N(NUM_ST), .W(SUM_W)) u_max0 (.vals_i(sums_u0), .max_o(max_u0));
    llrx_max_tree #(.N(NUM_ST), .W(SUM_W)) u_max1 (.vals_i(sums_u1), .max_o(max_u1));

    assign llr_c   = LLR_W'(max_u1) - LLR_W'(max_u0);
    assign ext_raw = RAW_W'(llr_c) - RAW_W'(sys_q) - RAW_W'(apri_q);

    llrx_ext_sat #(.RAW_W(RAW_W), .EXT_W(EXT_W)) u_sat (
        .raw_i (ext_raw),
        .ext_o (ext_sat)
    );

    llrx_window_lifo #(.DATA_W(DATA_W), .DEPTH(WIN_LEN)) u_lifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (vld_q),
        .last_i     (last_q),
        .data_i     ({llr_c, ext_sat}),
        .pop_vld_o  (out_valid_o),
        .pop_data_o (pop_data)
    );

    assign llr_o = pop_data[DATA_W-1 -: LLR_W];
    assign ext_o = pop_data[EXT_W-1:0];

endmodule

// File: rtl/llr_ext_unit_chk.sv
// Property checker for llr_ext_unit, attached with bind.
// Watches the input framing rules, the saturation boundaries and the
// balance between symbols accepted and results emitted.
module llr_ext_unit_chk #(
    parameter int WIN_LEN = 16,
    parameter int RAW_W   = 15
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid_i,
    input logic                    in_last_i,
    input logic                    out_valid_o,
    input logic signed [RAW_W-1:0] ext_raw,
    input logic signed [5:0]       ext_sat
);
    localparam logic signed [RAW_W-1:0] HI_R = RAW_W'(31);
    localparam logic signed [RAW_W-1:0] LO_R = RAW_W'(-32);

    int sym_cnt;
    int pending;

    // Count symbols inside the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sym_cnt <= 0;
        else if (in_valid_i && in_last_i) sym_cnt <= 0;
        else if (in_valid_i)              sym_cnt <= sym_cnt + 1;
    end

    // Count symbols accepted but not yet emitted.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 0;
        else        pending <= pending + int'(in_valid_i) - int'(out_valid_o);
    end

    // R7
    win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |-> (sym_cnt < WIN_LEN));

    // R7
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_last_i) |=> !in_valid_i);

    // R5
    no_phantom_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (pending > 0));

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid_o);

    // R3
    in_range_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext_raw <= HI_R) && (ext_raw >= LO_R)) |-> (RAW_W'(ext_sat) == ext_raw));

    // R4
    clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_raw > HI_R) |-> (ext_sat == 6'sd31));

    // R4
    clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_raw < LO_R) |-> (ext_sat == -6'sd32));

endmodule

bind llr_ext_unit llr_ext_unit_chk #(
    .WIN_LEN (WIN_LEN),
    .RAW_W   (RAW_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_last_i   (in_last_i),
    .out_valid_o (out_valid_o),
    .ext_raw     (ext_raw),
    .ext_sat     (ext_sat)
);

// File: tb/llr_ext_unit_tb_top.sv
// Self-checking bench for llr_ext_unit. A behavioural model computes each
// symbol's LLR and extrinsic from the requirements and schedules the exact
// output cycle. Every clock is compared against that schedule.
module llr_ext_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WIN_LEN    = 16;
    localparam int METRIC_W   = 10;
    localparam int GAMMA_W    = 8;
    localparam int IN_W       = 8;
    localparam int LLR_W      = METRIC_W + 3;

    typedef struct {
        int    cyc;
        int    llr;
        int    ext;
        string tag;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_last = 1'b0;
    logic [8*METRIC_W-1:0]   alpha = '0;
    logic [8*METRIC_W-1:0]   beta = '0;
    logic [4*GAMMA_W-1:0]    gamma = '0;
    logic [IN_W-1:0]         sys = '0;
    logic [IN_W-1:0]         apri = '0;
    logic                    out_valid;
    logic [LLR_W-1:0]        llr;
    logic [5:0]              ext;

    int   checks = 0;
    int   errors = 0;
    int   edge_n = 0;
    bit   mon_on = 1'b0;
    bit   done   = 1'b0;
    int   last_out = -100;
    exp_t exp_q[$];
    exp_t win_q[$];
    int   cur_a[8];
    int   cur_b[8];
    int   cur_g[4];
    int   cur_sys;
    int   cur_apri;

    llr_ext_unit #(
        .WIN_LEN  (WIN_LEN),
        .METRIC_W (METRIC_W),
        .GAMMA_W  (GAMMA_W),
        .IN_W     (IN_W)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_last_i   (in_last),
        .alpha_i     (alpha),
        .beta_i      (beta),
        .gamma_i     (gamma),
        .sys_i       (sys),
        .apri_i      (apri),
        .out_valid_o (out_valid),
        .llr_o       (llr),
        .ext_o       (ext)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) edge_n <= edge_n + 1;

    // Record one comparison result.
    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", what, act, expv, edge_n);
        end
    endtask

    // Reference LLR from the trellis of R1 and the maximum rule of R2.
    function automatic int ref_llr();
        int m1 = -(1 << 30);
        int m0 = -(1 << 30);
        for (int s = 0; s < 8; s++) begin
            for (int u = 0; u < 2; u++) begin
                int d0 = s & 1;
                int d1 = (s >> 1) & 1;
                int d2 = (s >> 2) & 1;
                int fb = u ^ d1 ^ d2;
                int p  = fb ^ d0 ^ d2;
                int ns = ((s << 1) & 6) | fb;
                int tot = cur_a[s] + cur_g[u * 2 + p] + cur_b[ns];
                if (u == 1 && tot > m1) m1 = tot;
                if (u == 0 && tot > m0) m0 = tot;
            end
        end
        return m1 - m0;
    endfunction

    // Saturation of R3/R4.
    function automatic int clamp6(input int v);
        if (v > 31) return 31;
        if (v < -32) return -32;
        return v;
    endfunction

    // Random metrics within ranges that respect the port widths.
    task automatic rand_fill();
        for (int i = 0; i < 8; i++) begin
            cur_a[i] = int'($urandom_range(400)) - 200;
            cur_b[i] = int'($urandom_range(400)) - 200;
        end
        for (int i = 0; i < 4; i++) cur_g[i] = int'($urandom_range(200)) - 100;
        cur_sys  = int'($urandom_range(200)) - 100;
        cur_apri = int'($urandom_range(200)) - 100;
    endtask

    // Present one symbol; on the last one schedule its window's outputs.
    task automatic drive_sym(input bit last, input string tag);
        exp_t e;
        int   t_edge;
        int   first;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            alpha[i*METRIC_W +: METRIC_W] = METRIC_W'(cur_a[i]);
            beta[i*METRIC_W +: METRIC_W]  = METRIC_W'(cur_b[i]);
        end
        for (int i = 0; i < 4; i++) gamma[i*GAMMA_W +: GAMMA_W] = GAMMA_W'(cur_g[i]);
        sys      = IN_W'(cur_sys);
        apri     = IN_W'(cur_apri);
        in_valid = 1'b1;
        in_last  = last;
        e.llr = ref_llr();
        e.ext = clamp6(e.llr - cur_sys - cur_apri);
        e.tag = tag;
        e.cyc = 0;
        win_q.push_back(e);
        if (last) begin
            t_edge = edge_n + 1;
            first  = (t_edge + 3 > last_out + 2) ? t_edge + 3 : last_out + 2;
            for (int k = 0; k < win_q.size(); k++) begin
                e = win_q[win_q.size() - 1 - k];
                e.cyc = first + k;
                exp_q.push_back(e);
            end
            last_out = first + win_q.size() - 1;
            win_q.delete();
        end
    endtask

    // Idle input cycles carrying garbage data (R9).
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = $urandom_range(1);
            alpha    = {$urandom, $urandom, $urandom};
            beta     = {$urandom, $urandom, $urandom};
            gamma    = $urandom;
            sys      = IN_W'($urandom);
            apri     = IN_W'($urandom);
        end
    endtask

    // One random window of the given length followed by the mandatory gap.
    task automatic rand_window(input int len, input string tag);
        for (int k = 0; k < len; k++) begin
            rand_fill();
            drive_sym(k == len - 1, tag);
        end
        idle(1);
    endtask

    // Corner symbol: LLR forced to x, then side terms applied (R4).
    task automatic corner_sym(input int x, input int s, input int a, input bit last);
        for (int i = 0; i < 8; i++) begin
            cur_a[i] = 0;
            cur_b[i] = 0;
        end
        cur_g[0] = 0;
        cur_g[1] = 0;
        cur_g[2] = x;
        cur_g[3] = x;
        cur_sys  = s;
        cur_apri = a;
        drive_sym(last, "R4");
    endtask

    // Per-clock comparison against the scheduled outputs (R5, R6).
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (exp_q.size() > 0 && exp_q[0].cyc == edge_n) begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_valid === 1'b1, "R6 out_valid on schedule", int'(out_valid), 1);
                check($signed(llr) == e.llr, "R1/R2/R5 llr", int'($signed(llr)), e.llr);
                check($signed(ext) == e.ext, {e.tag, " ext"}, int'($signed(ext)), e.ext);
            end else begin
                check(out_valid === 1'b0, "R6 out_valid idle", int'(out_valid), 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d pending outputs", exp_q.size(), 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(4);
        check(out_valid === 1'b0, "R8 out_valid after reset", int'(out_valid), 0);

        // Full-length windows back to back with the one-cycle gap.
        rand_window(WIN_LEN, "R3");
        rand_window(WIN_LEN, "R3");
        rand_window(WIN_LEN, "R3");
        idle(2 * WIN_LEN + 8);

        // Single-symbol windows streaming.
        for (int w = 0; w < 4; w++) rand_window(1, "R7");
        idle(2 * WIN_LEN + 8);

        // Short windows streaming.
        for (int w = 0; w < 3; w++) rand_window(3, "R7");
        idle(2 * WIN_LEN + 8);

        // Window with idle gaps between its symbols.
        for (int k = 0; k < 5; k++) begin
            rand_fill();
            drive_sym(k == 4, "R9");
            idle(k + 1);
        end
        idle(2 * WIN_LEN + 8);

        // Saturation corners: exact limits and one step beyond.
        corner_sym(31, 0, 0, 1'b0);
        corner_sym(32, 0, 0, 1'b0);
        corner_sym(-32, 0, 0, 1'b0);
        corner_sym(-33, 0, 0, 1'b0);
        corner_sym(100, 40, 29, 1'b0);
        corner_sym(100, 40, 28, 1'b0);
        corner_sym(-100, -40, -28, 1'b0);
        corner_sym(-100, -40, -27, 1'b0);
        corner_sym(127, -100, -100, 1'b0);
        corner_sym(-128, 100, 100, 1'b1);
        idle(2 * WIN_LEN + 8);

        // Mixed lengths after a drain-safe gap.
        rand_window(7, "R5");
        idle(2 * WIN_LEN + 8);
        rand_window(WIN_LEN, "R7");

        while (exp_q.size() > 0) @(negedge clk);
        idle(6);
        check(exp_q.size() == 0, "R5 all results emitted", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule